// File: doc/BRIEF.md
# External Reset Pulse Generator

This block turns a single-cycle expiry request from a watchdog into a reset pulse on a pad. The pulse length is programmed in microseconds and counted on a 1 MHz tick input, so the pulse is independent of the fast system clock. The level that means "reset" (high or low) and the way the pad is driven (push-pull or open-drain) are both chosen by software through one 32-bit register.

The register holds a pulse-width field in its low bits. A value of N gives a pulse of N+1 ticks. The two mode bits sit at the top of the register and are protected. They change only when one of four key bytes is written to bits 31:24. Any other top byte leaves both modes as they were, but the width field is still loaded from the same write. The pad side gives a data output and an output-enable, so one pin can serve either drive style.

Top module: `rpc_top`

## Requirements
- R1: After reset the register reads 0x000000FF. This means active-low, open-drain, and a 256-tick pulse. The pad is idle, with pad_oe=0 and pad_out=0.
- R2: Every write loads the width field, bits WIDTH_W-1:0, from wr_data. Register bits 29:WIDTH_W always read as zero.
- R3: Writing top byte 0xA5 sets bit 31, which selects active-high. Writing top byte 0x5A clears bit 31, which selects active-low.
- R4: Writing top byte 0xA8 sets bit 30, which selects push-pull. Writing top byte 0x8A clears bit 30, which selects open-drain.
- R5: A write whose top byte is none of the four keys leaves bits 31:30 unchanged.
- R6: The pulse is asserted at the pads in the clock cycle after the cycle in which trigger is high.
- R7: With width value N latched at the trigger, the pulse stays asserted through N tick cycles. It is released in the cycle after the (N+1)th tick.
- R8: A trigger that arrives while a pulse is running reloads the width. A further N+1 ticks are then counted from that trigger.
- R9: In push-pull mode pad_oe is always 1. pad_out equals bit 31 while the pulse is asserted, and its inverse while idle.
- R10: In open-drain mode pad_out is always 0. For active-low, pad_oe is 1 only while the pulse is asserted. For active-high, pad_oe is 1 only while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value: bit 31 polarity, bit 30 drive mode, low bits width |
| tick_1us | input | 1 | One-cycle 1 MHz timebase strobe |
| trigger | input | 1 | One-cycle pulse request |
| pad_out | output | 1 | Pad data output |
| pad_oe | output | 1 | Pad output enable |

## Verification
A register write shows on rd_data one clock after the strobe, so the bench drives each write for one cycle on a falling edge and reads back on the next falling edge. A trigger asserts the pads one clock later. Each tick moves the countdown one clock later, so the release appears one clock after the (N+1)th tick. The bench samples the pads on the falling edge after each tick and after each idle gap, and compares them with a model that counts ticks independently.

// File: rtl/rpc_pkg.sv
// Package: shared constants and helpers for the reset pulse generator.
// Assumes a 32-bit register whose top byte carries the mode keys.
package rpc_pkg;

    localparam int unsigned REG_W = 32;

    localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
    localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
    localparam logic [7:0] KEY_DRV_PP   = 8'hA8;
    localparam logic [7:0] KEY_DRV_OD   = 8'h8A;

    typedef enum logic { POL_LOW = 1'b0, POL_HIGH = 1'b1 } pol_e;
    typedef enum logic { DRV_OD  = 1'b0, DRV_PP   = 1'b1 } drv_e;

    typedef struct packed {
        pol_e pol;
        drv_e drv;
    } mode_t;

    // Returns the mode after a write with the given top byte applied.
    function automatic mode_t apply_key(input mode_t cur, input logic [7:0] key);
        mode_t nxt;
        nxt = cur;
        unique case (key)
            KEY_POL_HIGH: nxt.pol = POL_HIGH;
            KEY_POL_LOW:  nxt.pol = POL_LOW;
            KEY_DRV_PP:   nxt.drv = DRV_PP;
            KEY_DRV_OD:   nxt.drv = DRV_OD;
            default:      nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/rpc_cfg_reg.sv
// Module: configuration register with key-guarded mode bits.
// The width field loads on every write. The two mode bits change only on a
// matching key byte. Assumes WIDTH_W <= 30.
module rpc_cfg_reg
    import rpc_pkg::*;
#(
    parameter int unsigned WIDTH_W   = 20,
    parameter logic [WIDTH_W-1:0] WIDTH_RST = WIDTH_W'(8'hFF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    output logic [WIDTH_W-1:0] width_q,
    output mode_t              mode_q
);
    localparam int unsigned GAP_W = REG_W - 2 - WIDTH_W;

    // Register update: width always, mode via key decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q <= WIDTH_RST;
            mode_q  <= '{pol: POL_LOW, drv: DRV_OD};
        end else if (wr_en) begin
            width_q <= wr_data[WIDTH_W-1:0];
            mode_q  <= apply_key(mode_q, wr_data[REG_W-1 -: 8]);
        end
    end

    // Read view assembly; the gap exists only for narrow width fields.
    generate
        if (GAP_W > 0) begin : g_gap
            assign rd_data = {mode_q.pol, mode_q.drv, {GAP_W{1'b0}}, width_q};
        end else begin : g_nogap
            assign rd_data = {mode_q.pol, mode_q.drv, width_q};
        end
    endgenerate

endmodule

// File: rtl/rpc_pulse_timer.sv
// Module: pulse duration counter on the microsecond tick.
// A trigger loads the width value and raises the pulse the next cycle. Each
// tick decrements the count. The tick that arrives at zero ends the pulse,
// giving N+1 ticks in all. A trigger takes priority over a tick.
module rpc_pulse_timer #(
    parameter int unsigned WIDTH_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trigger,
    input  logic               tick,
    input  logic [WIDTH_W-1:0] width,
    output logic               pulse_on
);
    logic [WIDTH_W-1:0] remain_q;

    // Countdown and pulse flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            pulse_on <= 1'b0;
        end else if (trigger) begin
            remain_q <= width;
            pulse_on <= 1'b1;
        end else if (pulse_on && tick) begin
            if (remain_q == '0) begin
                pulse_on <= 1'b0;
            end else begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/rpc_pad_drive.sv
// Module: maps pulse state and mode to the pad data and output-enable.
// Open-drain can only pull low. It enables the driver in whichever phase the
// line must sit low, and holds the data output at 0.
module rpc_pad_drive
    import rpc_pkg::*;
(
    input  logic  pulse_on,
    input  mode_t mode,
    output logic  pad_out,
    output logic  pad_oe
);
    logic level_hi;

    // Decide the wanted line level, then how to produce it.
    always_comb begin
        level_hi = (mode.pol == POL_HIGH) ? pulse_on : !pulse_on;
        if (mode.drv == DRV_PP) begin
            pad_out = level_hi;
            pad_oe  = 1'b1;
        end else begin
            pad_out = 1'b0;
            pad_oe  = !level_hi;
        end
    end

endmodule

// File: rtl/rpc_top.sv
// Module: reset pulse generator top.
// It ties the config register, the tick-based duration timer and the pad
// mapping together. Assumes tick_1us is a one-cycle strobe in the clk domain.
module rpc_top #(
    parameter int unsigned WIDTH_W = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        tick_1us,
    input  logic        trigger,
    output logic        pad_out,
    output logic        pad_oe
);
    import rpc_pkg::*;

    logic [WIDTH_W-1:0] width_q;
    mode_t              mode_q;
    logic               pulse_on;

    rpc_cfg_reg #(.WIDTH_W(WIDTH_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .width_q(width_q), .mode_q(mode_q)
    );

    rpc_pulse_timer #(.WIDTH_W(WIDTH_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .trigger(trigger), .tick(tick_1us),
        .width(width_q), .pulse_on(pulse_on)
    );

    rpc_pad_drive u_pad (
        .pulse_on(pulse_on), .mode(mode_q), .pad_out(pad_out), .pad_oe(pad_oe)
    );

endmodule

// File: rtl/rpc_checker.sv
// Checker: temporal properties for rpc_top, attached by bind below.
module rpc_checker #(
    parameter int unsigned WIDTH_W = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        trigger,
    input logic        tick,
    input logic        pulse_on,
    input logic        pad_out,
    input logic        pad_oe
);
    logic key_hit;
    assign key_hit = (wr_data[31:24] == 8'hA5) || (wr_data[31:24] == 8'h5A) ||
                     (wr_data[31:24] == 8'hA8) || (wr_data[31:24] == 8'h8A);

    p_width_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[WIDTH_W-1:0] == $past(wr_data[WIDTH_W-1:0]));
    p_pol_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:24] == 8'hA5) |=> rd_data[31]);
    p_drv_pp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:24] == 8'hA8) |=> rd_data[30]);
    p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !key_hit) |=> rd_data[31:30] == $past(rd_data[31:30]));
    p_trig_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> pulse_on);
    p_end_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_on) |-> ($past(tick) && !$past(trigger)));
    p_pp_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[30] |-> pad_oe);
    p_od_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[30] |-> !pad_out);

endmodule

bind rpc_top rpc_checker #(.WIDTH_W(WIDTH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .trigger(trigger), .tick(tick_1us),
    .pulse_on(pulse_on), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/tb_rpc_top.sv
module tb_rpc_top;
    localparam int unsigned W = 20;
    localparam logic [31:0] WMASK = (32'h1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic tick_1us = 1'b0;
    logic trigger = 1'b0;
    logic pad_out, pad_oe;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic m_pol = 1'b0, m_pp = 1'b0;
    logic [31:0] m_width = 32'hFF;

    always #10 clk = ~clk;

    rpc_top #(.WIDTH_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick_1us(tick_1us), .trigger(trigger),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [31:0] exp_reg();
        return {m_pol, m_pp, 30'd0} | (m_width & WMASK);
    endfunction

    function automatic logic [1:0] exp_pad(input logic act);
        logic lvl;
        lvl = m_pol ? act : !act;
        if (m_pp) return {1'b1, lvl};
        return {!lvl, 1'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m_width = d & WMASK;
        case (d[31:24])
            8'hA5: m_pol = 1'b1;
            8'h5A: m_pol = 1'b0;
            8'hA8: m_pp = 1'b1;
            8'h8A: m_pp = 1'b0;
            default: ;
        endcase
    endtask

    task automatic pad_check(input string req, input logic act);
        check(req, {30'd0, pad_oe, pad_out}, {30'd0, exp_pad(act)});
    endtask

    task automatic give_tick();
        @(negedge clk); tick_1us = 1'b1;
        @(negedge clk); tick_1us = 1'b0;
    endtask

    task automatic fire();
        @(negedge clk); trigger = 1'b1;
        @(negedge clk); trigger = 1'b0;
    endtask

    // Program modes and width, then walk one pulse tick by tick (R6, R7, R9, R10).
    task automatic run_pulse(input int n, input logic pol, input logic pp);
        do_write({pol ? 8'hA5 : 8'h5A, 24'(n)});
        do_write({pp ? 8'hA8 : 8'h8A, 24'(n)});
        pad_check(pp ? "R9 idle" : "R10 idle", 1'b0);
        fire();
        pad_check("R6 start", 1'b1);
        for (int k = 0; k <= n; k++) begin
            @(negedge clk);
            pad_check(pp ? "R9 gap" : "R10 gap", 1'b1);
            give_tick();
            if (k < n) pad_check("R7 hold", 1'b1);
            else       pad_check("R7 release", 1'b0);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reg", rd_data, 32'h0000_00FF);
        check("R1 pad", {30'd0, pad_oe, pad_out}, 32'd0);

        // Directed key cases.
        do_write(32'hA5_00_0012); check("R3 high", rd_data, exp_reg());
        do_write(32'h5A_0F_FFFF); check("R3 low / R2 width", rd_data, exp_reg());
        do_write(32'hA8_00_0003); check("R4 pp", rd_data, exp_reg());
        do_write(32'h8A_00_0004); check("R4 od", rd_data, exp_reg());
        do_write(32'hA5_00_0000);
        do_write(32'hFF_FF_FFFF); check("R5 other key / R2 upper zero", rd_data, exp_reg());
        do_write(32'hA4_00_0007); check("R5 near key", rd_data, exp_reg());

        // Random register writes.
        for (int i = 0; i < 40; i++) begin
            logic [31:0] d;
            logic [7:0] keys [4];
            keys[0] = 8'hA5; keys[1] = 8'h5A; keys[2] = 8'hA8; keys[3] = 8'h8A;
            d = $urandom;
            if ($urandom_range(0, 1)) d[31:24] = keys[$urandom_range(0, 3)];
            do_write(d);
            check("R2 R3 R4 R5 random", rd_data, exp_reg());
        end

        // Pulses in every mode, including width zero.
        run_pulse(0, 1'b0, 1'b0);
        run_pulse(2, 1'b1, 1'b0);
        run_pulse(1, 1'b0, 1'b1);
        run_pulse(3, 1'b1, 1'b1);
        for (int i = 0; i < 8; i++)
            run_pulse($urandom_range(0, 6), 1'($urandom), 1'($urandom));

        // R8: retrigger in mid-pulse restarts the full count.
        do_write(32'h5A_00_0004);
        do_write(32'hA8_00_0004);
        fire();
        give_tick(); give_tick();
        fire();
        pad_check("R8 still on", 1'b1);
        for (int k = 0; k < 4; k++) give_tick();
        pad_check("R8 hold after 4", 1'b1);
        give_tick();
        pad_check("R8 release after 5", 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule